// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port in which the controller is always the clock master. It drives a shift clock on one pin and moves data over a second, bidirectional data pin. The data pin is split into output, output-enable and input signals. A frame is eight bits, least significant bit first. Each bit occupies a fixed number of system clocks, chosen at the start of the frame by a speed-select bit.

Writing a byte while the port is idle starts a transmission. While the port is idle, holding the receive-enable input high with the receive-done flag clear starts a reception. During a reception the data pin is released, and the input is captured on each rising edge of the shift clock. When a frame completes, the matching done flag is set. The flag holds until software pulses its clear input. The received byte sits in its own buffer, apart from the transmit byte, and stays there until the next reception completes.

Top module: `ssp_shift_port`

## Requirements
- R1: While reset is asserted, and after it is released, the shift clock is high, the data output-enable is low, both done flags are 0 and the received byte is 0x00. Asserting reset mid-frame returns the port to this state at once.
- R2: A frame carries 8 bits, least significant first. During a transmission, bit k is on the data output for the whole k-th bit period, and the output-enable is high for the whole frame.
- R3: With the speed bit at 1, the bit period is 4 clocks. The shift clock falls 1 clock after the bit starts, stays low for 2 clocks and is high for the last clock.
- R4: With the speed bit at 0, the bit period is 12 clocks. The shift clock falls 3 clocks after the bit starts, stays low for 6 clocks and is high for the last 3 clocks.
- R5: A write strobe while idle loads the byte and starts a frame at the next clock edge. The frame lasts exactly 8 bit periods.
- R6: While idle, receive-enable high with the receive-done flag clear starts a reception. The output-enable stays low, and the data input is taken at each rising edge of the shift clock. The assembled byte appears on the received-byte output when the frame ends.
- R7: The transmit-done or receive-done flag is set at the end of the eighth bit period of its frame. It stays set until its clear input is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R8: Between frames, the shift clock stays high and the output-enable stays low.
- R9: Write strobes and changes of the speed bit during a frame have no effect on that frame, and they do not queue a second frame.
- R10: If a write strobe and a reception start condition occur in the same idle cycle, a transmission starts.
- R11: While the receive-done flag is set, no reception starts, even with receive-enable held high, and the received byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the transmit byte |
| wr_data_i | input | 8 | Byte to transmit |
| rx_en_i | input | 1 | Receive enable |
| fast_i | input | 1 | Speed select: 1 = divide by 4, 0 = divide by 12 |
| clr_tx_done_i | input | 1 | Clears the transmit-done flag |
| clr_rx_done_i | input | 1 | Clears the receive-done flag |
| dat_i | input | 1 | Data pin input |
| sclk_o | output | 1 | Shift clock, idles high |
| dat_o | output | 1 | Data pin output |
| dat_oe_o | output | 1 | Data pin output enable |
| rx_data_o | output | 8 | Received byte buffer |
| tx_done_o | output | 1 | Transmit-done flag |
| rx_done_o | output | 1 | Receive-done flag |

## Verification
A phase counter off by one shows up within one bit period as a shift-clock edge one clock early or late. A wrong latched speed shows within the first 4 clocks, because the clock falls at the wrong position. A bit counter fault appears at the end of the frame as a done flag that arrives 4 or 12 clocks early or late. A shift-register fault appears as a wrong data bit during the affected bit period, or as a wrong byte in the receive buffer once the frame completes. Faults in the start gating show as shift-clock activity during cycles that should be idle. The bench watches the shift clock and the output-enable on every cycle, so any of these faults is caught within a few clocks of when it occurs.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned FAST_DIV   = 4;
  localparam int unsigned FAST_SETUP = 1;
  localparam int unsigned FAST_LOW   = 2;
  localparam int unsigned SLOW_DIV   = 12;
  localparam int unsigned SLOW_SETUP = 3;
  localparam int unsigned SLOW_LOW   = 6;

  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;
endpackage

// File: rtl/ssp_bit_timer.sv
module ssp_bit_timer #(
  parameter int unsigned FAST_DIV   = ssp_pkg::FAST_DIV,
  parameter int unsigned FAST_SETUP = ssp_pkg::FAST_SETUP,
  parameter int unsigned FAST_LOW   = ssp_pkg::FAST_LOW,
  parameter int unsigned SLOW_DIV   = ssp_pkg::SLOW_DIV,
  parameter int unsigned SLOW_SETUP = ssp_pkg::SLOW_SETUP,
  parameter int unsigned SLOW_LOW   = ssp_pkg::SLOW_LOW
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  input  logic fast_i,
  output logic sclk_low_o,
  output logic sample_o,
  output logic bit_end_o
);
  localparam int unsigned MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int unsigned PH_W    = $clog2(MAX_DIV);
  localparam logic [PH_W-1:0] F_LAST = PH_W'(FAST_DIV - 1);
  localparam logic [PH_W-1:0] F_FALL = PH_W'(FAST_SETUP);
  localparam logic [PH_W-1:0] F_RISE = PH_W'(FAST_SETUP + FAST_LOW);
  localparam logic [PH_W-1:0] S_LAST = PH_W'(SLOW_DIV - 1);
  localparam logic [PH_W-1:0] S_FALL = PH_W'(SLOW_SETUP);
  localparam logic [PH_W-1:0] S_RISE = PH_W'(SLOW_SETUP + SLOW_LOW);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] last, fall, rise;

  assign last = fast_i ? F_LAST : S_LAST;
  assign fall = fast_i ? F_FALL : S_FALL;
  assign rise = fast_i ? F_RISE : S_RISE;

  assign sclk_low_o = run_i && (ph_q >= fall) && (ph_q < rise);
  // last cycle before the rising edge: data is captured on this edge
  assign sample_o   = run_i && (ph_q == rise - PH_W'(1));
  assign bit_end_o  = run_i && (ph_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ph_q <= '0;
    else if (start_i)   ph_q <= '0;
    else if (run_i)     ph_q <= bit_end_o ? '0 : ph_q + PH_W'(1);
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned DATA_W = ssp_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic [DATA_W-1:0] rx_sh_o
);
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_sh_q <= '0;
    else if (load_i)  tx_sh_q <= load_data_i;
    else if (shift_i) tx_sh_q <= {1'b0, tx_sh_q[DATA_W-1:1]};
  end

  // LSB arrives first, so it ends up at bit 0 after DATA_W samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_sh_q <= '0;
    else if (sample_i) rx_sh_q <= {din_i, rx_sh_q[DATA_W-1:1]};
  end

  assign dout_o  = tx_sh_q[0];
  assign rx_sh_o = rx_sh_q;
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W = ssp_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rx_en_i,
  input  logic              fast_i,
  input  logic              clr_tx_done_i,
  input  logic              clr_rx_done_i,
  input  logic              bit_end_i,
  input  logic [DATA_W-1:0] rx_sh_i,
  output logic              start_o,
  output logic              load_o,
  output logic              busy_o,
  output dir_e              dir_o,
  output logic              fast_sel_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tx_done_o,
  output logic              rx_done_o
);
  localparam int unsigned BC_W = $clog2(DATA_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

  logic            busy_q, fast_q, tx_done_q, rx_done_q;
  dir_e            dir_q;
  logic [BC_W-1:0] bit_q;
  logic [DATA_W-1:0] rx_buf_q;
  logic            start_tx, start_rx, frame_end;

  // transmit wins over a reception start in the same cycle
  assign start_tx  = !busy_q && wr_i;
  assign start_rx  = !busy_q && !wr_i && rx_en_i && !rx_done_q;
  assign frame_end = busy_q && bit_end_i && (bit_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dir_q  <= DIR_TX;
      fast_q <= 1'b0;
      bit_q  <= '0;
    end else if (start_tx || start_rx) begin
      busy_q <= 1'b1;
      dir_q  <= start_rx ? DIR_RX : DIR_TX;
      fast_q <= fast_i;
      bit_q  <= '0;
    end else if (frame_end) begin
      busy_q <= 1'b0;
    end else if (busy_q && bit_end_i) begin
      bit_q  <= bit_q + BC_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
      rx_buf_q  <= '0;
    end else begin
      if (frame_end && dir_q == DIR_TX) tx_done_q <= 1'b1;
      else if (clr_tx_done_i)           tx_done_q <= 1'b0;
      if (frame_end && dir_q == DIR_RX) begin
        rx_done_q <= 1'b1;
        rx_buf_q  <= rx_sh_i;
      end else if (clr_rx_done_i) begin
        rx_done_q <= 1'b0;
      end
    end
  end

  assign start_o    = start_tx || start_rx;
  assign load_o     = start_tx;
  assign busy_o     = busy_q;
  assign dir_o      = dir_q;
  assign fast_sel_o = fast_q;
  assign rx_data_o  = rx_buf_q;
  assign tx_done_o  = tx_done_q;
  assign rx_done_o  = rx_done_q;
endmodule

// File: rtl/ssp_shift_port.sv
module ssp_shift_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W     = ssp_pkg::DATA_W,
  parameter int unsigned FAST_DIV   = ssp_pkg::FAST_DIV,
  parameter int unsigned FAST_SETUP = ssp_pkg::FAST_SETUP,
  parameter int unsigned FAST_LOW   = ssp_pkg::FAST_LOW,
  parameter int unsigned SLOW_DIV   = ssp_pkg::SLOW_DIV,
  parameter int unsigned SLOW_SETUP = ssp_pkg::SLOW_SETUP,
  parameter int unsigned SLOW_LOW   = ssp_pkg::SLOW_LOW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rx_en_i,
  input  logic              fast_i,
  input  logic              clr_tx_done_i,
  input  logic              clr_rx_done_i,
  input  logic              dat_i,
  output logic              sclk_o,
  output logic              dat_o,
  output logic              dat_oe_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tx_done_o,
  output logic              rx_done_o
);
  logic start, load, busy, fast_sel;
  logic sclk_low, sample, bit_end, sh_out;
  dir_e rx_dir;
  logic [DATA_W-1:0] rx_sh;

  ssp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .rx_en_i, .fast_i, .clr_tx_done_i, .clr_rx_done_i,
    .bit_end_i  (bit_end),
    .rx_sh_i    (rx_sh),
    .start_o    (start),
    .load_o     (load),
    .busy_o     (busy),
    .dir_o      (rx_dir),
    .fast_sel_o (fast_sel),
    .rx_data_o, .tx_done_o, .rx_done_o
  );

  ssp_bit_timer #(
    .FAST_DIV(FAST_DIV), .FAST_SETUP(FAST_SETUP), .FAST_LOW(FAST_LOW),
    .SLOW_DIV(SLOW_DIV), .SLOW_SETUP(SLOW_SETUP), .SLOW_LOW(SLOW_LOW)
  ) u_timer (
    .clk_i, .rst_ni,
    .start_i    (start),
    .run_i      (busy),
    .fast_i     (fast_sel),
    .sclk_low_o (sclk_low),
    .sample_o   (sample),
    .bit_end_o  (bit_end)
  );

  ssp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i      (load),
    .load_data_i (wr_data_i),
    .shift_i     (bit_end && rx_dir == DIR_TX),
    .sample_i    (sample && rx_dir == DIR_RX),
    .din_i       (dat_i),
    .dout_o      (sh_out),
    .rx_sh_o     (rx_sh)
  );

  assign sclk_o   = !sclk_low;
  assign dat_oe_o = busy && rx_dir == DIR_TX;
  assign dat_o    = dat_oe_o ? sh_out : 1'b1;
endmodule

// File: rtl/ssp_shift_port_chk.sv
module ssp_shift_port_chk #(
  parameter int unsigned FAST_LOW = ssp_pkg::FAST_LOW,
  parameter int unsigned SLOW_LOW = ssp_pkg::SLOW_LOW
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic dat_o,
  input logic dat_oe_o,
  input logic tx_done_o,
  input logic rx_done_o,
  input logic clr_tx_done_i,
  input logic clr_rx_done_i,
  input logic busy_i,
  input logic rx_dir_i,
  input logic fast_sel_i
);
  logic [7:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_cnt <= '0;
    else if (!sclk_o) low_cnt <= low_cnt + 8'd1;
    else              low_cnt <= '0;
  end

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (sclk_o && !dat_oe_o));

  // R2
  tx_data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !rx_dir_i && !sclk_o) |-> $stable(dat_o));

  // R6
  rx_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rx_dir_i) |-> !dat_oe_o);

  // R3 R4
  low_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> (low_cnt == (fast_sel_i ? 8'(FAST_LOW) : 8'(SLOW_LOW))));

  // R7
  tx_flag_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_done_o) |-> !busy_i);

  // R7
  tx_flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_o && !clr_tx_done_i) |=> tx_done_o);

  // R7
  rx_flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_o && !clr_rx_done_i) |=> rx_done_o);

  // R11
  rx_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_o && !busy_i) |=> !(busy_i && rx_dir_i));
endmodule

bind ssp_shift_port ssp_shift_port_chk #(.FAST_LOW(FAST_LOW), .SLOW_LOW(SLOW_LOW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sclk_o        (sclk_o),
  .dat_o         (dat_o),
  .dat_oe_o      (dat_oe_o),
  .tx_done_o     (tx_done_o),
  .rx_done_o     (rx_done_o),
  .clr_tx_done_i (clr_tx_done_i),
  .clr_rx_done_i (clr_rx_done_i),
  .busy_i        (busy),
  .rx_dir_i      (rx_dir == ssp_pkg::DIR_RX),
  .fast_sel_i    (fast_sel)
);

// File: tb/ssp_shift_port_tb_top.sv
module ssp_shift_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] VEC [6] = '{10'h2A5, 10'h03C, 10'h396, 10'h1E1, 10'h201, 10'h180};

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rx_en_i = 1'b0, fast_i = 1'b0, dat_i = 1'b0;
  logic       clr_tx_done_i = 1'b0, clr_rx_done_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       sclk_o, dat_o, dat_oe_o, tx_done_o, rx_done_o;
  logic [7:0] rx_data_o;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssp_shift_port dut_i (
    .clk_i(clk), .rst_ni, .wr_i, .wr_data_i, .rx_en_i, .fast_i,
    .clr_tx_done_i, .clr_rx_done_i, .dat_i,
    .sclk_o, .dat_o, .dat_oe_o, .rx_data_o, .tx_done_o, .rx_done_o
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, "sclk idle", 32'(sclk_o), 32'd1);
    check(req, "oe idle", 32'(dat_oe_o), 32'd0);
  endtask

  // called at a negedge; returns at the negedge after the frame end
  task automatic run_frame(input logic fast, input logic rx, input logic [7:0] data,
                           input bit disturb, input bit both, input bit clear);
    int p, s, l, ph, b;
    logic exp_sclk;
    p = fast ? 4 : 12;
    s = fast ? 1 : 3;
    l = fast ? 2 : 6;
    fast_i = fast;
    if (rx) begin rx_en_i = 1'b1; dat_i = data[0]; end
    else begin wr_i = 1'b1; wr_data_i = data; rx_en_i = both; end
    @(posedge clk); @(negedge clk);
    wr_i = 1'b0; rx_en_i = 1'b0;
    for (int k = 0; k < 8*p; k++) begin
      ph = k % p;
      b  = k / p;
      exp_sclk = !(ph >= s && ph < s + l);
      check(fast ? "R3" : "R4", "sclk", 32'(sclk_o), 32'(exp_sclk));
      check(rx ? "R6" : (both ? "R10" : "R2"), "oe", 32'(dat_oe_o), 32'(!rx));
      if (!rx) check(disturb ? "R9" : "R2", "dat_o", 32'(dat_o), 32'(data[b]));
      else dat_i = data[b];
      if (disturb && k == 5) begin wr_i = 1'b1; wr_data_i = ~data; fast_i = ~fast; end
      if (disturb && k == 6) begin wr_i = 1'b0; fast_i = fast; end
      @(negedge clk);
    end
    check("R5", "frame length / flag", 32'(rx ? rx_done_o : tx_done_o), 32'd1);
    check_idle("R8");
    if (rx) check("R6", "rx byte", 32'(rx_data_o), 32'(data));
    if (disturb) begin
      repeat (2 * p) begin
        @(negedge clk);
        check_idle("R9");
      end
    end
    if (clear) begin
      @(negedge clk);
      check("R7", "flag held", 32'(rx ? rx_done_o : tx_done_o), 32'd1);
      if (rx) clr_rx_done_i = 1'b1; else clr_tx_done_i = 1'b1;
      @(posedge clk); @(negedge clk);
      clr_rx_done_i = 1'b0; clr_tx_done_i = 1'b0;
      check("R7", "flag cleared", 32'(rx ? rx_done_o : tx_done_o), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R1: during reset
    check_idle("R1");
    check("R1", "tx_done", 32'(tx_done_o), 32'd0);
    check("R1", "rx_done", 32'(rx_done_o), 32'd0);
    check("R1", "rx_data", 32'(rx_data_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check_idle("R1");

    foreach (VEC[i]) run_frame(VEC[i][9], VEC[i][8], VEC[i][7:0], 1'b0, 1'b0, 1'b1);

    // R9: write and speed flip mid-frame
    run_frame(1'b0, 1'b0, 8'hA5, 1'b1, 1'b0, 1'b1);
    // R10: write and reception start together
    run_frame(1'b1, 1'b0, 8'h5A, 1'b0, 1'b1, 1'b1);
    check("R10", "no rx flag", 32'(rx_done_o), 32'd0);

    // R11: receive-done left set blocks further receptions
    run_frame(1'b1, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b0);
    held = rx_data_o;
    rx_en_i = 1'b1;
    dat_i = 1'b0;
    repeat (20) begin
      @(negedge clk);
      check("R11", "sclk blocked", 32'(sclk_o), 32'd1);
    end
    check("R11", "rx_data held", 32'(rx_data_o), 32'(held));
    rx_en_i = 1'b0;
    clr_rx_done_i = 1'b1;
    @(posedge clk); @(negedge clk);
    clr_rx_done_i = 1'b0;
    check("R7", "rx flag cleared", 32'(rx_done_o), 32'd0);
    run_frame(1'b0, 1'b1, 8'h3E, 1'b0, 1'b0, 1'b1);

    // R1: reset in the middle of a frame
    fast_i = 1'b0;
    wr_data_i = 8'hFF;
    wr_i = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", "sclk low mid-frame", 32'(sclk_o), 32'd0);
    rst_ni = 1'b0;
    #1;
    check_idle("R1");
    check("R1", "tx_done after reset", 32'(tx_done_o), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check_idle("R8");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule